// File: doc/BRIEF.md
# Address window decoder

This block is a bank of programmable address windows for a CPU-side interconnect. Each window covers a naturally aligned, power-of-two region of a 36-bit physical address space and names the device behind it by a 4-bit target and an 8-bit attribute. Software programs the windows through a simple 32-bit register bus. On each CPU request the block compares the address against every enabled window and reports, one cycle later, whether it hit, which window won, the device target and attribute, the window's sync-barrier flag, and the address to send to the device.

The eight low windows carry a 64-bit remap base. A hit on one of them replaces the window's base with the remap base and keeps the offset within the window. Windows above that pass the address through unchanged. A write to the unit sync-barrier register produces a one-cycle request to the units named by the written bits. A value of 0xFFFF requests a barrier on all units.

Top module: `adwin_decoder`

## Requirements
- R1: After reset every window is disabled. Every window register reads as zero, and every request misses.
- R2: Window control word: bit 0 enable, bit 1 sync-barrier flag, bits 7:4 target, bits 15:8 attribute, bits 31:16 window size minus one counted in 64 KiB granules. Bits 3:2 read back as zero.
- R3: Window base word: bits 31:16 hold address bits 31:16, and bits 3:0 hold address bits 35:32. All other bits read back as zero.
- R4: A request hits an enabled window when base <= address < base + (size field + 1) * 64 KiB. A disabled window never hits.
- R5: rsp_valid is high exactly one cycle after req_valid. The other response outputs change only in the cycle after a request.
- R6: On a hit the response carries the winning window's index, target, attribute and sync-barrier flag.
- R7: A hit on window 0..7 yields the address {remap_high[31:0], remap_low[31:16], 16'h0} OR (address AND (size - 1)). The remap-low register keeps only bits 31:16.
- R8: A hit on window 8..19 yields the request address zero-extended to 64 bits. These windows have no remap registers.
- R9: Register offsets are byte addresses. Window i<8: control 16*i, base 16*i+4, remap-low 16*i+8, remap-high 16*i+12. Window i>=8: control 0x90+8*(i-8), base 0x94+8*(i-8). Offsets 0x80, 0x88, 0x8C and offsets from 0xF0 up read as zero, and writes to them have no effect.
- R10: When several enabled windows match, the lowest-numbered one wins and rsp_overlap is set. With a single match rsp_overlap is clear.
- R11: A control write with bit 0 clear returns the whole window to zero: control, base and remap registers.
- R12: A write to offset 0x84 drives barrier_req with the written bits 15:0 for exactly one cycle. This offset reads as zero.
- R13: On a miss rsp_hit is low, window, target, attribute and sync flag are zero, and rsp_addr is the request address zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| barrier_req | output | 16 | One-cycle per-unit sync-barrier request |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 36 | Physical address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_hit | output | 1 | Some enabled window matched |
| rsp_win | output | 5 | Index of the winning window |
| rsp_target | output | 4 | Target of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_sync | output | 1 | Sync-barrier flag of the winning window |
| rsp_overlap | output | 1 | More than one enabled window matched |
| rsp_addr | output | 64 | Translated address |

## Verification
The bench probes each programmed window at five points: the address just below the base, the base, the middle, the last byte, and the first byte past the end.

- A comparator with an off-by-one error misses the last byte or claims the byte past the end.
- A window ending exactly at the top of the 36-bit space exposes a comparison that overflows.
- Nested and coincident windows check the priority picker and the overlap flag. A picker biased to the highest index returns the wrong target there.
- Probes after a window is disabled show whether its remap and base fields were really cleared.
- Full-ones register writes expose bits that should read as zero.
- Hole offsets and the split-stride map catch a decoder that places window 8 and above at the low-window stride.

// File: rtl/adwin_pkg.sv
package adwin_pkg;

    localparam int PA_W     = 36;
    localparam int GRAN_LSB = 16;
    localparam int PAGE_W   = PA_W - GRAN_LSB;
    localparam int XA_W     = 64;

    typedef struct packed {
        logic              en;
        logic              sync;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [15:0]       szm1;
        logic [PAGE_W-1:0] page;
        logic [15:0]       rlo;
        logic [31:0]       rhi;
    } win_cfg_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_BASE,
        RK_RLO,
        RK_RHI,
        RK_SYNC
    } reg_kind_e;

endpackage

// File: rtl/adwin_regs.sv
module adwin_regs
    import adwin_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int RA_W      = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [15:0]              barrier_o,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o
);

    localparam int IDX_W    = $clog2(NUM_WIN);
    localparam int LO_SPAN  = NUM_REMAP * 16;
    localparam int SYNC_OFF = LO_SPAN + 4;
    localparam int HI_BASE  = LO_SPAN + 16;
    localparam int HI_END   = HI_BASE + (NUM_WIN - NUM_REMAP) * 8;

    localparam logic [RA_W-1:0] LO_SPAN_A  = RA_W'(LO_SPAN);
    localparam logic [RA_W-1:0] SYNC_OFF_A = RA_W'(SYNC_OFF);
    localparam logic [RA_W-1:0] HI_BASE_A  = RA_W'(HI_BASE);
    localparam logic [RA_W-1:0] HI_END_A   = RA_W'(HI_END);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic [31:0]            rdata;
        logic [15:0]            barrier;
    } st_t;

    st_t              s_d, s_q;
    reg_kind_e        wr_kind;
    logic [IDX_W-1:0] sel;
    logic [RA_W-1:0]  hi_off;
    win_cfg_t         cur;
    logic [31:0]      rd_word;

    // Offset decode: two window regions with different strides, a hole between.
    always_comb begin
        wr_kind = RK_NONE;
        sel     = '0;
        hi_off  = reg_addr - HI_BASE_A;
        if (reg_addr < LO_SPAN_A) begin
            sel = IDX_W'(reg_addr >> 4);
            case (reg_addr[3:2])
                2'd0:    wr_kind = RK_CTRL;
                2'd1:    wr_kind = RK_BASE;
                2'd2:    wr_kind = RK_RLO;
                default: wr_kind = RK_RHI;
            endcase
        end else if (reg_addr[RA_W-1:2] == SYNC_OFF_A[RA_W-1:2]) begin
            wr_kind = RK_SYNC;
        end else if (reg_addr >= HI_BASE_A && reg_addr < HI_END_A) begin
            sel     = IDX_W'(NUM_REMAP) + IDX_W'(hi_off >> 3);
            wr_kind = reg_addr[2] ? RK_BASE : RK_CTRL;
        end
    end

    always_comb begin
        cur = s_q.win[sel];
        case (wr_kind)
            RK_CTRL: rd_word = {cur.szm1, cur.attr, cur.tgt, 2'b00, cur.sync, cur.en};
            RK_BASE: rd_word = {cur.page[15:0], 12'h000, cur.page[PAGE_W-1:16]};
            RK_RLO:  rd_word = {cur.rlo, 16'h0000};
            RK_RHI:  rd_word = cur.rhi;
            default: rd_word = 32'h0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        s_d.barrier = '0;
        if (reg_wr) begin
            case (wr_kind)
                RK_CTRL: begin
                    if (reg_wdata[0]) begin
                        s_d.win[sel].en   = 1'b1;
                        s_d.win[sel].sync = reg_wdata[1];
                        s_d.win[sel].tgt  = reg_wdata[7:4];
                        s_d.win[sel].attr = reg_wdata[15:8];
                        s_d.win[sel].szm1 = reg_wdata[31:16];
                    end else begin
                        s_d.win[sel] = '0;
                    end
                end
                RK_BASE: s_d.win[sel].page = {reg_wdata[3:0], reg_wdata[31:16]};
                RK_RLO:  s_d.win[sel].rlo  = reg_wdata[31:16];
                RK_RHI:  s_d.win[sel].rhi  = reg_wdata;
                RK_SYNC: s_d.barrier       = reg_wdata[15:0];
                default: ;
            endcase
        end
        if (reg_rd) begin
            s_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o     = s_q.win;
    assign reg_rdata = s_q.rdata;
    assign barrier_o = s_q.barrier;

    p_barrier_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wr_kind == RK_SYNC) |=> (barrier_o == $past(reg_wdata[15:0])));

    p_barrier_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && wr_kind == RK_SYNC) |=> (barrier_o == 16'h0));

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_chk
        p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && wr_kind == RK_CTRL && sel == IDX_W'(g) && !reg_wdata[0])
            |=> (cfg_o[g] == '0));
        if (g >= NUM_REMAP) begin : g_hi
            p_no_remap_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_o[g].rlo == 16'h0) && (cfg_o[g].rhi == 32'h0));
        end
    end

endmodule

// File: rtl/adwin_match.sv
module adwin_match
    import adwin_pkg::*;
#(
    parameter int NUM_WIN = 20
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic [PA_W-1:0]        addr_i,
    output logic [NUM_WIN-1:0]     hit_o
);

    // One comparator per window on the 64 KiB page number; the subtraction
    // is one bit wider so an address below the base shows up as a borrow.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [PAGE_W:0] diff;
        assign diff = {1'b0, addr_i[PA_W-1:GRAN_LSB]} - {1'b0, cfg_i[g].page};
        assign hit_o[g] = cfg_i[g].en && !diff[PAGE_W]
                          && (diff[PAGE_W-1:0] <= PAGE_W'(cfg_i[g].szm1));
    end

endmodule

// File: rtl/adwin_pick.sv
module adwin_pick
    import adwin_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int IDX_W     = $clog2(NUM_WIN)
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic [NUM_WIN-1:0]     hit_i,
    input  logic [PA_W-1:0]        addr_i,
    output logic                   hit_o,
    output logic                   overlap_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic [3:0]             tgt_o,
    output logic [7:0]             attr_o,
    output logic                   sync_o,
    output logic [XA_W-1:0]        xaddr_o
);

    win_cfg_t        sel;
    logic [XA_W-1:0] pass;
    logic [XA_W-1:0] size_m1;
    logic [XA_W-1:0] remap_base;

    always_comb begin
        hit_o     = |hit_i;
        overlap_o = (hit_i & (hit_i - 1'b1)) != '0;
        idx_o     = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end

        sel        = cfg_i[idx_o];
        pass       = {{(XA_W - PA_W){1'b0}}, addr_i};
        size_m1    = {32'h0, sel.szm1, 16'hFFFF};
        remap_base = {sel.rhi, sel.rlo, 16'h0000};

        tgt_o   = '0;
        attr_o  = '0;
        sync_o  = 1'b0;
        xaddr_o = pass;
        if (hit_o) begin
            tgt_o  = sel.tgt;
            attr_o = sel.attr;
            sync_o = sel.sync;
            if (idx_o < IDX_W'(NUM_REMAP)) begin
                xaddr_o = remap_base | (pass & size_m1);
            end
        end
    end

endmodule

// File: rtl/adwin_decoder.sv
module adwin_decoder
    import adwin_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int RA_W      = 12,
    parameter int IDX_W     = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [15:0]      barrier_req,
    input  logic             req_valid,
    input  logic [35:0]      req_addr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_win,
    output logic [3:0]       rsp_target,
    output logic [7:0]       rsp_attr,
    output logic             rsp_sync,
    output logic             rsp_overlap,
    output logic [63:0]      rsp_addr
);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             overlap;
        logic             sync;
        logic [IDX_W-1:0] win;
        logic [3:0]       tgt;
        logic [7:0]       attr;
        logic [XA_W-1:0]  xaddr;
    } rsp_t;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hit_vec;
    logic                   c_hit, c_ovl, c_sync;
    logic [IDX_W-1:0]       c_idx;
    logic [3:0]             c_tgt;
    logic [7:0]             c_attr;
    logic [XA_W-1:0]        c_xaddr;
    rsp_t                   rsp_d, rsp_q;

    adwin_regs #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .RA_W      (RA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .barrier_o (barrier_req),
        .cfg_o     (cfg)
    );

    adwin_match #(
        .NUM_WIN (NUM_WIN)
    ) u_match (
        .cfg_i  (cfg),
        .addr_i (req_addr),
        .hit_o  (hit_vec)
    );

    adwin_pick #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .IDX_W     (IDX_W)
    ) u_pick (
        .cfg_i     (cfg),
        .hit_i     (hit_vec),
        .addr_i    (req_addr),
        .hit_o     (c_hit),
        .overlap_o (c_ovl),
        .idx_o     (c_idx),
        .tgt_o     (c_tgt),
        .attr_o    (c_attr),
        .sync_o    (c_sync),
        .xaddr_o   (c_xaddr)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit     = c_hit;
            rsp_d.overlap = c_ovl;
            rsp_d.sync    = c_sync;
            rsp_d.win     = c_idx;
            rsp_d.tgt     = c_tgt;
            rsp_d.attr    = c_attr;
            rsp_d.xaddr   = c_xaddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_overlap = rsp_q.overlap;
    assign rsp_sync    = rsp_q.sync;
    assign rsp_win     = rsp_q.win;
    assign rsp_target  = rsp_q.tgt;
    assign rsp_attr    = rsp_q.attr;
    assign rsp_addr    = rsp_q.xaddr;

    p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                        && $stable(rsp_target)));

    p_overlap_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> rsp_hit);

    p_miss_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_target == 4'h0 && rsp_attr == 8'h0
                      && rsp_win == '0 && !rsp_sync));

    p_miss_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_hit) |=> (rsp_addr == {28'h0, $past(req_addr)}));

endmodule

// File: tb/adwin_decoder_tb.sv
`timescale 1ns/1ps
module adwin_decoder_tb;

    localparam int NW = 20;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] barrier_req;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_sync, rsp_overlap;
    logic [4:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [63:0] rsp_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_ctrl [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_rlo  [NR];
    logic [31:0] m_rhi  [NR];

    always #2.5 clk = ~clk;

    adwin_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .barrier_req(barrier_req),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
        .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_sync(rsp_sync),
        .rsp_overlap(rsp_overlap), .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] off_ctrl(input int i);
        if (i < NR) return 12'(i * 16);
        return 12'(144 + (i - NR) * 8);
    endfunction

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr_ctrl(input int i, input logic [31:0] d);
        bus_wr(off_ctrl(i), d);
        if (d[0]) m_ctrl[i] = d;
        else begin
            m_ctrl[i] = '0; m_base[i] = '0;
            if (i < NR) begin m_rlo[i] = '0; m_rhi[i] = '0; end
        end
    endtask

    task automatic prog(input int i, input logic [35:0] base, input logic [15:0] szm1,
                        input logic [3:0] tgt, input logic [7:0] attr, input logic sy,
                        input logic [31:0] rlo, input logic [31:0] rhi);
        bus_wr(off_ctrl(i) + 12'd4, {base[31:16], 12'h0, base[35:32]});
        m_base[i] = {base[31:16], 12'h0, base[35:32]};
        if (i < NR) begin
            bus_wr(off_ctrl(i) + 12'd8, rlo);  m_rlo[i] = rlo;
            bus_wr(off_ctrl(i) + 12'd12, rhi); m_rhi[i] = rhi;
        end
        wr_ctrl(i, {szm1, attr, tgt, 2'b00, sy, 1'b1});
    endtask

    // Expected decode from the requirement arithmetic (R4, R6, R7, R8, R10, R13).
    task automatic dec_check(input logic [35:0] a);
        logic [63:0] a64, lo, sz, e_xa;
        logic e_hit, e_ov, e_sync;
        logic [4:0] e_win;
        logic [3:0] e_tgt;
        logic [7:0] e_attr;
        a64 = {28'h0, a};
        e_hit = 0; e_ov = 0; e_sync = 0; e_win = 0; e_tgt = 0; e_attr = 0; e_xa = a64;
        for (int i = 0; i < NW; i++) begin
            lo = {28'h0, m_base[i][3:0], m_base[i][31:16], 16'h0};
            sz = ({48'h0, m_ctrl[i][31:16]} + 64'd1) << 16;
            if (m_ctrl[i][0] && a64 >= lo && a64 < lo + sz) begin
                if (!e_hit) begin
                    e_hit = 1; e_win = 5'(i);
                    e_tgt = m_ctrl[i][7:4]; e_attr = m_ctrl[i][15:8]; e_sync = m_ctrl[i][1];
                    if (i < NR) e_xa = {m_rhi[i], m_rlo[i][31:16], 16'h0} | (a64 & (sz - 64'd1));
                end else begin
                    e_ov = 1;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk($sformatf("R5 valid @%h", a), {63'h0, rsp_valid}, 64'd1);
        chk($sformatf("R4 hit @%h", a), {63'h0, rsp_hit}, {63'h0, e_hit});
        chk($sformatf("R6 win @%h", a), {59'h0, rsp_win}, {59'h0, e_win});
        chk($sformatf("R6 target @%h", a), {60'h0, rsp_target}, {60'h0, e_tgt});
        chk($sformatf("R6 attr @%h", a), {56'h0, rsp_attr}, {56'h0, e_attr});
        chk($sformatf("R6 sync @%h", a), {63'h0, rsp_sync}, {63'h0, e_sync});
        chk($sformatf("R10 overlap @%h", a), {63'h0, rsp_overlap}, {63'h0, e_ov});
        chk($sformatf("R7/R8/R13 addr @%h", a), rsp_addr, e_xa);
    endtask

    task automatic sweep_win(input int i);
        logic [63:0] lo, sz;
        lo = {28'h0, m_base[i][3:0], m_base[i][31:16], 16'h0};
        sz = ({48'h0, m_ctrl[i][31:16]} + 64'd1) << 16;
        if (lo != 0) dec_check(36'(lo - 64'd1));
        dec_check(36'(lo));
        dec_check(36'(lo + (sz >> 1)));
        dec_check(36'(lo + sz - 64'd1));
        if (lo + sz < 64'h10_0000_0000) dec_check(36'(lo + sz));
    endtask

    initial begin
        logic [31:0] d;
        logic [63:0] held;
        int wl[6];
        wl = '{0, 2, 5, 9, 12, 19};
        for (int i = 0; i < NW; i++) begin m_ctrl[i] = '0; m_base[i] = '0; end
        for (int i = 0; i < NR; i++) begin m_rlo[i] = '0; m_rhi[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < NW; i++) begin
            bus_rd(off_ctrl(i), d);           chk($sformatf("R1 ctrl w%0d", i), {32'h0, d}, 64'h0);
            bus_rd(off_ctrl(i) + 12'd4, d);   chk($sformatf("R1 base w%0d", i), {32'h0, d}, 64'h0);
            if (i < NR) begin
                bus_rd(off_ctrl(i) + 12'd8, d);  chk($sformatf("R1 rlo w%0d", i), {32'h0, d}, 64'h0);
                bus_rd(off_ctrl(i) + 12'd12, d); chk($sformatf("R1 rhi w%0d", i), {32'h0, d}, 64'h0);
            end
        end
        dec_check(36'h0);
        dec_check(36'h0_1000_0000);
        dec_check(36'hF_FFFF_FFFF);
        chk("R1 barrier idle", {48'h0, barrier_req}, 64'h0);

        // R2, R3, R7, R9: field layout on window 3
        bus_wr(12'h034, 32'hFFFF_FFFF);
        bus_wr(12'h038, 32'hFFFF_FFFF);
        bus_wr(12'h03C, 32'hFFFF_FFFF);
        bus_wr(12'h030, 32'hFFFF_FFFF);
        bus_rd(12'h030, d); chk("R2 ctrl readback", {32'h0, d}, 64'hFFFF_FFF3);
        bus_rd(12'h034, d); chk("R3 base readback", {32'h0, d}, 64'hFFFF_000F);
        bus_rd(12'h038, d); chk("R7 remap-low readback", {32'h0, d}, 64'hFFFF_0000);
        bus_rd(12'h03C, d); chk("R7 remap-high readback", {32'h0, d}, 64'hFFFF_FFFF);
        // R11: disable clears the whole window
        bus_wr(12'h030, 32'hFFFF_FFFE);
        bus_rd(12'h030, d); chk("R11 ctrl cleared", {32'h0, d}, 64'h0);
        bus_rd(12'h034, d); chk("R11 base cleared", {32'h0, d}, 64'h0);
        bus_rd(12'h038, d); chk("R11 rlo cleared", {32'h0, d}, 64'h0);
        bus_rd(12'h03C, d); chk("R11 rhi cleared", {32'h0, d}, 64'h0);

        // R9: hole and unmapped offsets
        bus_wr(12'h080, 32'hFFFF_FFFF);
        bus_wr(12'h088, 32'hFFFF_FFFF);
        bus_wr(12'h08C, 32'hFFFF_FFFF);
        bus_wr(12'h0F0, 32'hFFFF_FFFF);
        bus_wr(12'h0FC, 32'hFFFF_FFFF);
        bus_rd(12'h080, d); chk("R9 hole 0x80", {32'h0, d}, 64'h0);
        bus_rd(12'h088, d); chk("R9 hole 0x88", {32'h0, d}, 64'h0);
        bus_rd(12'h08C, d); chk("R9 hole 0x8C", {32'h0, d}, 64'h0);
        bus_rd(12'h0F0, d); chk("R9 beyond 0xF0", {32'h0, d}, 64'h0);
        bus_rd(12'h070, d); chk("R9 w7 ctrl untouched", {32'h0, d}, 64'h0);
        bus_rd(12'h07C, d); chk("R9 w7 rhi untouched", {32'h0, d}, 64'h0);
        bus_rd(12'h090, d); chk("R9 w8 ctrl untouched", {32'h0, d}, 64'h0);
        bus_rd(12'h0EC, d); chk("R9 w19 base untouched", {32'h0, d}, 64'h0);
        dec_check(36'h0_0000_1234);

        // R12: sync barrier
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h084; reg_wdata = 32'h0000_FFFF;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R12 barrier pulse", {48'h0, barrier_req}, 64'hFFFF);
        @(negedge clk);
        chk("R12 barrier one cycle", {48'h0, barrier_req}, 64'h0);
        bus_rd(12'h084, d); chk("R12 barrier reads zero", {32'h0, d}, 64'h0);

        // Program decode set
        prog(0,  36'h0_1000_0000, 16'h00FF, 4'h1, 8'h2E, 1'b1, 32'hABCD_0000, 32'h0000_0001);
        prog(2,  36'h0_1080_0000, 16'h0000, 4'h2, 8'h11, 1'b0, 32'h5555_0000, 32'h0000_0002);
        prog(5,  36'h2_0000_0000, 16'hFFFF, 4'h5, 8'hE0, 1'b1, 32'h0000_0000, 32'h0000_0080);
        prog(9,  36'hF_FFF0_0000, 16'h000F, 4'h9, 8'h77, 1'b0, 32'h0, 32'h0);
        prog(12, 36'h0_1000_0000, 16'h01FF, 4'hC, 8'h3C, 1'b1, 32'h0, 32'h0);
        prog(19, 36'h0_8000_0000, 16'h0001, 4'hF, 8'hFF, 1'b0, 32'h0, 32'h0);
        bus_rd(12'h0E8, d); chk("R9 w19 ctrl at 0xE8", {32'h0, d}, 64'h0001_FFF1);
        bus_rd(12'h0EC, d); chk("R3 w19 base at 0xEC", {32'h0, d}, 64'h8000_0000);

        // R4, R6, R7, R8, R10, R13: boundary sweeps
        foreach (wl[k]) sweep_win(wl[k]);
        dec_check(36'h0);
        dec_check(36'hF_FFFF_FFFF);

        // R5: response held while idle
        dec_check(36'h0_1080_0000);
        held = rsp_addr;
        @(negedge clk);
        chk("R5 idle valid low", {63'h0, rsp_valid}, 64'd0);
        chk("R5 idle addr held", rsp_addr, held);

        // R11, R10: disable window 0, lower-priority windows take over
        wr_ctrl(0, 32'h0);
        sweep_win(2);
        sweep_win(12);
        dec_check(36'h0_1000_0000);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule